// File: doc/BRIEF.md
# Compare Timer Channel Pair

This block provides compare-based timer channels that share one free-running 64-bit system counter. The default build has two channels: index 0 serves as the physical timer and index 1 as the virtual timer. Each channel holds its own 64-bit compare value and a small control word. A channel reports an expired status whenever it is enabled and the counter has reached its compare value. It drives a level interrupt unless that interrupt is masked.

Software reaches a channel's compare value in two ways. The absolute view reads and writes the full 64-bit value. The relative view is a 32-bit signed countdown: a read returns the distance still to go, and a write arms the channel a given number of ticks ahead of (or behind) the present count. The counter advances by one on each cycle in which the tick-enable input is high; at a 62.5 MHz tick rate that is one count per 16 ns. Status and interrupt are recomputed from the registered state every cycle, so any write or tick shows at the outputs right after the edge that captures it.

Access uses a register selector. Code 0 is control, 1 is the absolute compare view, 2 is the relative view and 3 is the counter. Reads are combinational on the selected channel and selector.

Top module: `gen_cmp_timer`

## Requirements
- R1: After reset the counter, every compare value and every control word are 0, and all interrupt outputs are low.
- R2: The counter increments by exactly one on each clock edge where `tick_i` is high, and it holds its value otherwise.
- R3: Control bit 0 is enable and bit 1 is mask. A control write (selector 0) keeps only data bits 1:0. Bit 2 reads as the live status and cannot be written.
- R4: While enabled, status (control bit 2) is 1 exactly when the counter is greater than or equal to the compare value, taken as unsigned 64-bit numbers.
- R5: A channel's interrupt output is high exactly when its status is 1 and its mask bit is 0.
- R6: While enable is 0, status reads 0 and the interrupt is low, whatever the counter and compare values are.
- R7: An absolute write (selector 1) loads all 64 data bits into the compare value, and an absolute read returns it.
- R8: A relative read (selector 2) returns, zero-extended, the low 32 bits of compare value minus current counter.
- R9: A relative write sets the compare value to the counter at the write edge plus data bits 31:0 sign-extended to 64 bits.
- R10: A write addressed to one channel leaves the compare value and control bits of every other channel unchanged.
- R11: A write with selector 3 changes neither the counter nor any channel state. A read with selector 3 returns the counter, which also appears on `cnt_o`.
- R12: The effect of a write or a tick on status and interrupt is visible at the ports directly after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter advance enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_chan_i | input | CH_W (1) | Channel index of the write |
| wr_reg_i | input | 2 | Register selector of the write |
| wr_data_i | input | CNT_W (64) | Write data |
| rd_chan_i | input | CH_W (1) | Channel index of the read |
| rd_reg_i | input | 2 | Register selector of the read |
| rd_data_o | output | CNT_W (64) | Read data, combinational |
| irq_o | output | NUM_CH (2) | Level interrupt per channel |
| cnt_o | output | CNT_W (64) | Current system counter value |

## Verification
A corrupted compare value or counter shows up in the relative view in the same cycle, because that view reads the difference live. It also moves the status bit and the interrupt on the first edge where the comparison crosses over. A control bit that is captured wrongly appears on the next read of control and on the interrupt line directly after the write edge. Signed arithmetic in the comparator is exposed by compare values near the top of the 64-bit range. A wrong sign extension in the relative write is exposed by negative and extreme 32-bit values, which place the compare value either far ahead of the counter or just behind it.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int unsigned DEF_CNT_W  = 64;
  localparam int unsigned DEF_REL_W  = 32;
  localparam int unsigned DEF_NUM_CH = 2;

  typedef enum logic [1:0] {
    SEL_CTL = 2'd0,
    SEL_ABS = 2'd1,
    SEL_REL = 2'd2,
    SEL_CNT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/gtmr_status.sv
module gtmr_status #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mask_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             stat_o,
  output logic             irq_o
);
  logic reached;

  // unsigned compare: both operands are plain logic vectors
  assign reached = (cnt_i >= cmp_i);
  assign stat_o  = en_i & reached;
  assign irq_o   = stat_o & ~mask_i;

  // once reached, status stays while enabled and compare unchanged (counter only grows)
  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stat_o) && en_i && $stable(cmp_i) && cnt_i != '0) |-> stat_o); // R4
endmodule

// File: rtl/gtmr_chan.sv
module gtmr_chan #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned REL_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wr_ctl_i,
  input  logic             wr_abs_i,
  input  logic             wr_rel_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [2:0]       ctl_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic [REL_W-1:0] rel_o,
  output logic             irq_o
);
  localparam int unsigned EXT_W = CNT_W - REL_W;

  logic             en_q;
  logic             mask_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] rel_sext;
  logic             stat;

  assign rel_sext = {{EXT_W{wdata_i[REL_W-1]}}, wdata_i[REL_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
    end else if (wr_ctl_i) begin
      en_q   <= wdata_i[0];
      mask_q <= wdata_i[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '0;
    else if (wr_abs_i) cmp_q <= wdata_i;
    else if (wr_rel_i) cmp_q <= cnt_i + rel_sext;
  end

  gtmr_status #(.CNT_W(CNT_W)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .mask_i (mask_q),
    .cmp_i  (cmp_q),
    .cnt_i  (cnt_i),
    .stat_o (stat),
    .irq_o  (irq_o)
  );

  assign ctl_o = {stat, mask_q, en_q};
  assign cmp_o = cmp_q;
  assign rel_o = REL_W'(cmp_q - cnt_i);

  AST_CTL_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl_i |=> ctl_o[1:0] == $past(wdata_i[1:0])); // R3
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl_i && !wdata_i[0]) |=> (!irq_o && !ctl_o[2])); // R6
  AST_ABS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_abs_i |=> cmp_o == $past(wdata_i)); // R7
  AST_REL_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rel_i && !wr_abs_i) |=> REL_W'(cmp_o - $past(cnt_i)) == $past(wdata_i[REL_W-1:0])); // R9
endmodule

// File: rtl/gen_cmp_timer.sv
module gen_cmp_timer
  import gtmr_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned REL_W  = DEF_REL_W,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_chan_i,
  input  logic [1:0]        wr_reg_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [CH_W-1:0]   rd_chan_i,
  input  logic [1:0]        rd_reg_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic [CNT_W-1:0]  cnt_o
);
  reg_sel_e         wsel;
  reg_sel_e         rsel;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       ctl_a [NUM_CH];
  logic [CNT_W-1:0] cmp_a [NUM_CH];
  logic [REL_W-1:0] rel_a [NUM_CH];

  assign wsel = reg_sel_e'(wr_reg_i);
  assign rsel = reg_sel_e'(rd_reg_i);

  gtmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (cnt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit = wr_en_i && (int'(wr_chan_i) == i);

    gtmr_chan #(.CNT_W(CNT_W), .REL_W(REL_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cnt_i    (cnt),
      .wr_ctl_i (hit && wsel == SEL_CTL),
      .wr_abs_i (hit && wsel == SEL_ABS),
      .wr_rel_i (hit && wsel == SEL_REL),
      .wdata_i  (wr_data_i),
      .ctl_o    (ctl_a[i]),
      .cmp_o    (cmp_a[i]),
      .rel_o    (rel_a[i]),
      .irq_o    (irq_o[i])
    );

    AST_CH_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && int'(wr_chan_i) != i) |=> ($stable(cmp_a[i]) && $stable(ctl_a[i][1:0]))); // R10
    AST_CNT_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wsel == SEL_CNT) |=> ($stable(cmp_a[i]) && $stable(ctl_a[i][1:0]))); // R11
    AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] |-> (!ctl_a[i][1] && ctl_a[i][2])); // R5
  end

  always_comb begin
    rd_data_o = '0;
    if (rsel == SEL_CNT) begin
      rd_data_o = cnt;
    end else if (int'(rd_chan_i) < NUM_CH) begin
      case (rsel)
        SEL_CTL: rd_data_o = CNT_W'(ctl_a[rd_chan_i]);
        SEL_ABS: rd_data_o = cmp_a[rd_chan_i];
        SEL_REL: rd_data_o = CNT_W'(rel_a[rd_chan_i]);
        default: rd_data_o = '0;
      endcase
    end
  end

  assign cnt_o = cnt;
endmodule

// File: tb/gen_cmp_timer_test.sv
module gen_cmp_timer_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [0:0]  wr_chan_i = '0;
  logic [1:0]  wr_reg_i = '0;
  logic [63:0] wr_data_i = '0;
  logic [0:0]  rd_chan_i = '0;
  logic [1:0]  rd_reg_i = '0;
  logic [63:0] rd_data_o;
  logic [1:0]  irq_o;
  logic [63:0] cnt_o;

  int checks = 0;
  int errors = 0;

  logic [63:0] mcnt = '0;
  logic [63:0] mcmp [2];
  logic [1:0]  mctl [2];

  logic [31:0] rel_vals [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h5, 32'hFFFF_FFFB,
                                32'h7FFF_FFFF, 32'h8000_0000, 32'h0001_0000};

  always #2 clk = ~clk;

  gen_cmp_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .wr_en_i(wr_en_i), .wr_chan_i(wr_chan_i), .wr_reg_i(wr_reg_i), .wr_data_i(wr_data_i),
    .rd_chan_i(rd_chan_i), .rd_reg_i(rd_reg_i), .rd_data_o(rd_data_o),
    .irq_o(irq_o), .cnt_o(cnt_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [1:0] sel, input logic [63:0] d);
    wr_en_i = 1'b1; wr_chan_i = ch[0]; wr_reg_i = sel; wr_data_i = d;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
    if (sel == 2'd0) mctl[ch] = d[1:0];
    else if (sel == 2'd1) mcmp[ch] = d;
    else if (sel == 2'd2) mcmp[ch] = mcnt + {{32{d[31]}}, d[31:0]};
  endtask

  task automatic rd(input int ch, input logic [1:0] sel, output logic [63:0] v);
    rd_chan_i = ch[0]; rd_reg_i = sel;
    @(negedge clk);
    v = rd_data_o;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      tick_i = 1'b1;
      repeat (n) @(posedge clk);
      #1;
      tick_i = 1'b0;
      mcnt = mcnt + 64'(n);
    end
  endtask

  function automatic logic stat_of(input int ch);
    return mctl[ch][0] && (mcnt >= mcmp[ch]);
  endfunction

  task automatic chk_chan(input string req, input int ch);
    logic [63:0] v;
    logic s;
    s = stat_of(ch);
    rd(ch, 2'd0, v);
    chk(req, $sformatf("ch%0d ctl", ch), v, {61'b0, s, mctl[ch]});
    rd(ch, 2'd1, v);
    chk(req, $sformatf("ch%0d cmp", ch), v, mcmp[ch]);
    chk(req, $sformatf("ch%0d irq", ch), 64'(irq_o[ch]), 64'(s && !mctl[ch][1]));
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] v;
    mcmp[0] = '0; mcmp[1] = '0; mctl[0] = '0; mctl[1] = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 / R6: reset state; counter equals compare but channel disabled
    for (int ch = 0; ch < 2; ch++) begin
      chk_chan("R1", ch);
      rd(ch, 2'd2, v); chk("R1", "rel after reset", v, 64'h0);
    end
    rd(0, 2'd3, v); chk("R1", "counter after reset", v, 64'h0);
    chk("R6", "irq while disabled at reset", 64'(irq_o), 64'h0);

    // R2: counting and holding
    ticks(5);
    rd(0, 2'd3, v); chk("R2", "counter after 5 ticks", v, 64'd5);
    repeat (3) @(posedge clk);
    #1;
    chk("R2", "counter holds without tick", cnt_o, 64'd5);

    // R12: crossing shows right after the tick edge
    wr(0, 2'd1, mcnt + 64'd2);
    wr(0, 2'd0, 64'h1);
    chk("R12", "irq before reach", 64'(irq_o[0]), 64'h0);
    ticks(1);
    chk("R12", "irq one short", 64'(irq_o[0]), 64'h0);
    ticks(1);
    chk("R12", "irq right after reaching edge", 64'(irq_o[0]), 64'h1);
    wr(0, 2'd0, 64'h0);
    chk("R12", "irq right after disable edge", 64'(irq_o[0]), 64'h0);

    // R3/R4/R5/R6: sweep control codes (bit 2 written to show it is ignored) and compare offsets
    for (int ch = 0; ch < 2; ch++) begin
      for (int c = 0; c < 8; c++) begin
        for (int d = -3; d <= 3; d++) begin
          wr(ch, 2'd1, mcnt + 64'(d));
          wr(ch, 2'd0, 64'(c));
          chk_chan(c[0] ? "R4" : "R6", ch);
          chk("R3", "ctl low bits kept", {62'b0, mctl[ch]}, 64'(c[1:0]));
          chk("R5", "irq vs status and mask", 64'(irq_o[ch]), 64'(stat_of(ch) && !c[1]));
          ticks(1);
        end
      end
    end

    // R4: unsigned comparison near the top of the range
    wr(1, 2'd1, 64'h8000_0000_0000_0000);
    wr(1, 2'd0, 64'h1);
    chk_chan("R4", 1);
    chk("R4", "upper-half compare not reached", 64'(irq_o[1]), 64'h0);
    wr(1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    chk_chan("R4", 1);

    // R7: absolute full-width round trip
    wr(1, 2'd1, 64'hFEDC_BA98_7654_3210);
    rd(1, 2'd1, v); chk("R7", "abs readback", v, 64'hFEDC_BA98_7654_3210);

    // R8/R9: relative writes and reads, including sign extension extremes
    wr(0, 2'd0, 64'h1);
    for (int ch = 0; ch < 2; ch++) begin
      for (int k = 0; k < 8; k++) begin
        wr(ch, 2'd2, {32'hA5A5_A5A5, rel_vals[k]});
        rd(ch, 2'd1, v); chk("R9", "rel write sets compare", v, mcmp[ch]);
        chk("R9", "rel write model", mcmp[ch], mcnt + {{32{rel_vals[k][31]}}, rel_vals[k]});
        rd(ch, 2'd2, v); chk("R8", "rel read back", v, {32'h0, rel_vals[k]});
        chk_chan("R9", ch);
        ticks(3);
        rd(ch, 2'd2, v); chk("R8", "rel read after 3 ticks", v, {32'h0, 32'(rel_vals[k] - 32'd3)});
        chk_chan("R4", ch);
      end
    end

    // R10: writes to channel 0 leave channel 1 alone
    wr(1, 2'd1, 64'h1234);
    wr(1, 2'd0, 64'h2);
    wr(0, 2'd1, 64'hDEAD_BEEF);
    wr(0, 2'd0, 64'h3);
    wr(0, 2'd2, 64'h10);
    chk_chan("R10", 1);
    rd(1, 2'd1, v); chk("R10", "ch1 cmp untouched", v, 64'h1234);
    wr(1, 2'd1, 64'h0);
    chk_chan("R10", 0);

    // R11: counter selector is read-only
    wr(0, 2'd3, 64'hFFFF_0000_FFFF_0000);
    rd(0, 2'd3, v); chk("R11", "counter not written", v, mcnt);
    chk("R11", "cnt_o matches", cnt_o, mcnt);
    chk_chan("R11", 0);
    chk_chan("R11", 1);

    summary();
    $finish;
  end
endmodule